// File: doc/BRIEF.md
# Receive Frame Class Combiner

This block turns a per-frame match word into a set of class decisions. The match word is built upstream. It carries traffic-type flags (unicast, multicast, broadcast and similar), two address-match flags, eight compare-slot matches and sixteen pattern-slot matches. The block holds a configurable number of classes, sixteen by default. Each class picks flags through two enable masks: one feeds an "any enabled flag set" term and the other feeds an "all enabled flags set" term. A 2-bit select mode then combines the two terms.

Each class also has a gate. When the raw bit is set, the class hits on every frame. The allow bit decides whether a hit is passed on. The phase bit is stored and read back, but it does not change hit or pass. Results are registered when a frame strobe arrives and stay the same until the next strobe. Software sets everything up through a word-addressed write port and a combinational read port.

Top module: `rxcls_combiner`

## Requirements
- R1: After reset, every AND-enable and OR-enable word reads 0 and the mode word reads 0 (every class uses "any"). Every gate reads 0x50 (allow bit 6 set, raw bit 5 clear, phase bit 4 set), and class_hit and class_pass are all 0.
- R2: The register map uses word addresses. Class n has its AND-enable at address 2n and its OR-enable at address 2n+1. The mode word is at address 32, with class n in bits 2n+1:2n. The gate of class n is at address 33+n, and only bits 6, 5 and 4 are kept; the other gate bits read as 0. Any other address reads 0, and a write to it changes nothing.
- R3: Mode 0 ("any"): the class hits when at least one flag set in its OR-enable is set in the frame's match word. With a zero OR-enable, the class never hits.
- R4: Mode 1 ("all"): the class hits when every flag set in its AND-enable is set in the match word. With a zero AND-enable, the class never hits.
- R5: Mode 2: the class hits only when both the "any" term and the "all" term are true.
- R6: Mode 3: the class hits when either the "any" term or the "all" term is true.
- R7: A class whose raw bit is set hits on every frame, whatever its enables and mode, including an all-zero match word.
- R8: class_pass of a class equals its hit ANDed with its allow bit. The phase bit has no effect on hit or pass.
- R9: Results update on the first clock edge after frm_valid is sampled high. While frm_valid is low they hold, whatever frm_flags does.
- R10: Match word layout: bit 31 unicast, bit 30 multicast, bit 29 broadcast, bit 28 forward, bit 27 receive, bit 26 VLAN, bit 25 destination equals port address, bit 24 destination equals interface address, bits 23:16 compare-slot matches, bits 15:0 pattern-slot matches. A class with OR-enable on bits 29 and 25 in mode 3 accepts broadcast frames and port-address frames. It rejects interface-address-only frames, and it rejects multicast frames unless bit 30 is also enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| frm_valid | input | 1 | Match word strobe, one per frame |
| frm_flags | input | 32 | Per-frame match word |
| class_hit | output | 16 | Per-class hit, held between strobes |
| class_pass | output | 16 | Per-class hit gated by allow |

## Verification
A corrupted enable, mode or gate register shows up in two places. It changes the register's own read-back at once, and it changes that class's hit or pass on the very next frame, one cycle after the strobe. A fault in the result registers shows up differently. Outputs may drift while no frame is present, or pass may rise without hit; the bench therefore watches idle stretches as well as strobe cycles. Each frame is compared across all sixteen classes, so one wrong bit in any class is caught on the first frame that exercises it.

// File: rtl/rxcls_pkg.sv
package rxcls_pkg;

    // Match-word flag positions (consumed by upstream builders)
    localparam int FLG_UCAST  = 31;
    localparam int FLG_MCAST  = 30;
    localparam int FLG_BCAST  = 29;
    localparam int FLG_FWD    = 28;
    localparam int FLG_RCV    = 27;
    localparam int FLG_VLAN   = 26;
    localparam int FLG_DA_PRT = 25;
    localparam int FLG_DA_IF  = 24;

    // Gate word bit positions
    localparam int GATE_ALLOW_BIT = 6;
    localparam int GATE_RAW_BIT   = 5;
    localparam int GATE_PHASE_BIT = 4;

    typedef enum logic [1:0] {
        SEL_ANY    = 2'd0,
        SEL_ALL    = 2'd1,
        SEL_BOTH   = 2'd2,
        SEL_EITHER = 2'd3
    } sel_mode_e;

endpackage

// File: rtl/rxcls_regs.sv
module rxcls_regs
    import rxcls_pkg::*;
#(
    parameter int NUM_CLASS = 16,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [WORD_W-1:0]                wdata,
    output logic [WORD_W-1:0]                rdata,
    output logic [NUM_CLASS-1:0][WORD_W-1:0] and_en,
    output logic [NUM_CLASS-1:0][WORD_W-1:0] or_en,
    output logic [NUM_CLASS-1:0][1:0]        mode,
    output logic [NUM_CLASS-1:0]             allow,
    output logic [NUM_CLASS-1:0]             raw
);

    localparam int MODE_W    = 2 * NUM_CLASS;
    localparam int MODE_ADDR = 2 * NUM_CLASS;
    localparam int GATE_BASE = MODE_ADDR + 1;
    localparam int GATE_END  = GATE_BASE + NUM_CLASS;

    typedef struct {
        logic [WORD_W-1:0]    and_en [NUM_CLASS];
        logic [WORD_W-1:0]    or_en  [NUM_CLASS];
        logic [MODE_W-1:0]    mode;
        logic [NUM_CLASS-1:0] allow;
        logic [NUM_CLASS-1:0] raw;
        logic [NUM_CLASS-1:0] phase;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        int a;
        a     = int'(addr);
        cfg_d = cfg_q;
        if (wr) begin
            if (a < MODE_ADDR) begin
                if (a % 2 == 1) cfg_d.or_en[a / 2]  = wdata;
                else            cfg_d.and_en[a / 2] = wdata;
            end else if (a == MODE_ADDR) begin
                cfg_d.mode = wdata[MODE_W-1:0];
            end else if (a < GATE_END) begin
                cfg_d.allow[a - GATE_BASE] = wdata[GATE_ALLOW_BIT];
                cfg_d.raw[a - GATE_BASE]   = wdata[GATE_RAW_BIT];
                cfg_d.phase[a - GATE_BASE] = wdata[GATE_PHASE_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CLASS; i++) begin
                cfg_q.and_en[i] <= '0;
                cfg_q.or_en[i]  <= '0;
            end
            cfg_q.mode  <= '0;
            cfg_q.allow <= '1;
            cfg_q.raw   <= '0;
            cfg_q.phase <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        int a;
        a     = int'(addr);
        rdata = '0;
        if (a < MODE_ADDR) begin
            rdata = (a % 2 == 1) ? cfg_q.or_en[a / 2] : cfg_q.and_en[a / 2];
        end else if (a == MODE_ADDR) begin
            rdata[MODE_W-1:0] = cfg_q.mode;
        end else if (a < GATE_END) begin
            rdata[GATE_ALLOW_BIT] = cfg_q.allow[a - GATE_BASE];
            rdata[GATE_RAW_BIT]   = cfg_q.raw[a - GATE_BASE];
            rdata[GATE_PHASE_BIT] = cfg_q.phase[a - GATE_BASE];
        end
    end

    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_out
        assign and_en[g] = cfg_q.and_en[g];
        assign or_en[g]  = cfg_q.or_en[g];
        assign mode[g]   = cfg_q.mode[2*g +: 2];
    end
    assign allow = cfg_q.allow;
    assign raw   = cfg_q.raw;

    // R2
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && int'(addr) >= GATE_END) |=> ($stable(cfg_q.mode) && $stable(cfg_q.allow)
                                           && $stable(cfg_q.raw)));

endmodule

// File: rtl/rxcls_eval.sv
module rxcls_eval
    import rxcls_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [WORD_W-1:0] flags,
    input  logic [WORD_W-1:0] and_en,
    input  logic [WORD_W-1:0] or_en,
    input  logic [1:0]        mode,
    input  logic              allow,
    input  logic              raw,
    output logic              hit,
    output logic              pass
);

    typedef struct packed {
        logic hit;
        logic pass;
    } res_t;

    res_t res_d, res_q;
    logic any_t, all_t, sel_t;

    always_comb begin
        any_t = |(flags & or_en);
        all_t = (and_en != '0) && ((flags & and_en) == and_en);
        case (sel_mode_e'(mode))
            SEL_ANY:    sel_t = any_t;
            SEL_ALL:    sel_t = all_t;
            SEL_BOTH:   sel_t = any_t & all_t;
            default:    sel_t = any_t | all_t;
        endcase
        res_d = res_q;
        if (valid) begin
            res_d.hit  = raw | sel_t;
            res_d.pass = (raw | sel_t) & allow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign hit  = res_q.hit;
    assign pass = res_q.pass;

    // R7
    raw_forces_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && raw) |=> hit);

    // R3
    no_enable_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !raw && or_en == '0 && and_en == '0) |=> !hit);

endmodule

// File: rtl/rxcls_combiner.sv
module rxcls_combiner
    import rxcls_pkg::*;
#(
    parameter int NUM_CLASS = 16,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic [WORD_W-1:0]    cfg_rdata,
    input  logic                 frm_valid,
    input  logic [WORD_W-1:0]    frm_flags,
    output logic [NUM_CLASS-1:0] class_hit,
    output logic [NUM_CLASS-1:0] class_pass
);

    logic [NUM_CLASS-1:0][WORD_W-1:0] and_en;
    logic [NUM_CLASS-1:0][WORD_W-1:0] or_en;
    logic [NUM_CLASS-1:0][1:0]        mode;
    logic [NUM_CLASS-1:0]             allow;
    logic [NUM_CLASS-1:0]             raw;

    rxcls_regs #(
        .NUM_CLASS (NUM_CLASS),
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .and_en (and_en),
        .or_en  (or_en),
        .mode   (mode),
        .allow  (allow),
        .raw    (raw)
    );

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        rxcls_eval #(.WORD_W(WORD_W)) u_eval (
            .clk    (clk),
            .rst_n  (rst_n),
            .valid  (frm_valid),
            .flags  (frm_flags),
            .and_en (and_en[c]),
            .or_en  (or_en[c]),
            .mode   (mode[c]),
            .allow  (allow[c]),
            .raw    (raw[c]),
            .hit    (class_hit[c]),
            .pass   (class_pass[c])
        );
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> ($stable(class_hit) && $stable(class_pass)));

    // R8
    pass_within_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (class_pass & ~class_hit) == '0);

endmodule

// File: tb/tb_rxcls_combiner.sv
module tb_rxcls_combiner;

    localparam int NC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        frm_valid = 1'b0;
    logic [31:0] frm_flags = '0;
    logic [NC-1:0] class_hit, class_pass;

    always #4 clk = ~clk;

    rxcls_combiner dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frm_valid(frm_valid),
        .frm_flags(frm_flags), .class_hit(class_hit), .class_pass(class_pass)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] m_and [NC];
    logic [31:0] m_or  [NC];
    logic [31:0] m_mode;
    logic [31:0] m_gate [NC];

    typedef struct {
        logic [NC-1:0] hit;
        logic [NC-1:0] pass;
        string         tag;
    } exp_t;
    exp_t q[$];
    logic [NC-1:0] last_hit = '0, last_pass = '0;
    logic vld_seen = 1'b0;

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mirror_read(int a);
        if (a < 32) return (a % 2 == 1) ? m_or[a/2] : m_and[a/2];
        if (a == 32) return m_mode;
        if (a < 49) return m_gate[a-33];
        return 32'h0;
    endfunction

    function automatic void model(logic [31:0] w, output logic [NC-1:0] h,
                                  output logic [NC-1:0] p);
        for (int c = 0; c < NC; c++) begin
            bit anyb = 0, allb = 1, anden = 0, sel;
            for (int b = 0; b < 32; b++) begin
                if (m_or[c][b] && w[b]) anyb = 1;
                if (m_and[c][b]) begin
                    anden = 1;
                    if (!w[b]) allb = 0;
                end
            end
            allb = allb && anden;
            case (m_mode[2*c +: 2])
                2'd0: sel = anyb;
                2'd1: sel = allb;
                2'd2: sel = anyb && allb;
                default: sel = anyb || allb;
            endcase
            h[c] = m_gate[c][5] || sel;
            p[c] = h[c] && m_gate[c][6];
        end
    endfunction

    task automatic cfg_write(int a, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 7'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a < 32) begin
            if (a % 2 == 1) m_or[a/2] = d; else m_and[a/2] = d;
        end else if (a == 32) m_mode = d;
        else if (a < 49) m_gate[a-33] = d & 32'h70;
    endtask

    task automatic cfg_check(int a, string tag);
        @(negedge clk);
        cfg_addr = 7'(a);
        #1;
        check32(tag, cfg_rdata, mirror_read(a));
    endtask

    task automatic set_mode(int c, logic [1:0] md);
        logic [31:0] w;
        w = m_mode;
        w[2*c +: 2] = md;
        cfg_write(32, w);
    endtask

    task automatic send(logic [31:0] w, string tag);
        exp_t e;
        @(negedge clk);
        model(w, e.hit, e.pass);
        e.tag = tag;
        q.push_back(e);
        frm_valid = 1'b1; frm_flags = w;
        @(negedge clk);
        frm_valid = 1'b0;
        frm_flags = ~w;
    endtask

    always @(posedge clk) vld_seen <= frm_valid;

    // monitor: compares one cycle after each strobe
    always @(negedge clk) begin
        if (vld_seen && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check32({e.tag, " hit"}, 32'(class_hit), 32'(e.hit));
            check32({e.tag, " pass (R8)"}, 32'(class_pass), 32'(e.pass));
            last_hit = e.hit;
            last_pass = e.pass;
        end
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NC; i++) begin
            m_and[i] = 0; m_or[i] = 0; m_gate[i] = 32'h50;
        end
        m_mode = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check32("R1 hit", 32'(class_hit), 32'h0);
        check32("R1 pass", 32'(class_pass), 32'h0);
        for (int a = 0; a < 49; a++) cfg_check(a, "R1 reset readback");

        // R2 map and field masking
        cfg_write(6, 32'hA5A5_0001);
        cfg_write(7, 32'h0F0F_F0F0);
        cfg_write(36, 32'hFFFF_FFFF);
        cfg_write(32, 32'h1234_5678);
        cfg_check(6, "R2 and-enable");
        cfg_check(7, "R2 or-enable");
        cfg_check(36, "R2 gate mask");
        cfg_check(32, "R2 mode word");
        cfg_write(100, 32'hFFFF_FFFF);
        cfg_check(100, "R2 unmapped read");
        cfg_check(32, "R2 unmapped write ignored");
        cfg_check(33, "R2 unmapped write ignored");
        cfg_write(6, 0); cfg_write(7, 0); cfg_write(36, 32'h50); cfg_write(32, 0);

        // R10 default class 0: broadcast or port address, mode 3
        cfg_write(1, 32'h2200_0000);
        set_mode(0, 2'd3);
        send(32'h2000_0000, "R10 broadcast");
        send(32'h8200_0000, "R10 port address");
        send(32'h8100_0000, "R10 interface only");
        send(32'h4000_0000, "R10 multicast rejected");
        cfg_write(1, 32'h6200_0000);
        send(32'h4000_0000, "R10 multicast accepted");

        // R3 any
        cfg_write(3, 32'h0000_00F0);
        send(32'h0000_0010, "R3 any hit");
        send(32'h0000_000F, "R3 any miss");

        // R4 all
        cfg_write(4, 32'h0003_0000);
        set_mode(2, 2'd1);
        set_mode(4, 2'd1);
        send(32'h0001_0000, "R4 partial");
        send(32'h0003_0000, "R4 full");
        send(32'hFFFF_FFFF, "R4 zero mask");

        // R5 both, R6 either
        cfg_write(10, 32'h0000_0003); cfg_write(11, 32'h8000_0000);
        cfg_write(12, 32'h0000_0003); cfg_write(13, 32'h8000_0000);
        set_mode(5, 2'd2);
        set_mode(6, 2'd3);
        send(32'h8000_0003, "R5 R6 both terms");
        send(32'h8000_0001, "R5 R6 any only");
        send(32'h0000_0003, "R5 R6 all only");
        send(32'h0000_0001, "R5 R6 neither");

        // R7 raw
        cfg_write(33 + 7, 32'h70);
        send(32'h0000_0000, "R7 raw zero word");

        // R8 allow cleared, phase cleared
        cfg_write(33 + 5, 32'h20);
        cfg_write(33 + 6, 32'h40);
        send(32'h8000_0003, "R8 allow and phase");

        // R9 hold while idle with changing flags
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            frm_flags = 32'hFFFF_FFFF >> i;
            @(negedge clk);
            check32("R9 hold hit", 32'(class_hit), 32'(last_hit));
            check32("R9 hold pass", 32'(class_pass), 32'(last_pass));
        end

        repeat (3) @(negedge clk);
        check32("R9 queue drained", 32'(q.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule